// File: doc/BRIEF.md
# Shifter Amount and Type Selector

This block sits in front of a 32-bit barrel shifter. It produces the 5-bit shift amount and the 2-bit shift kind that the shifter needs on every cycle. A 3-bit command from the instruction sequencer chooses where those two fields come from:

- the shift field written in the instruction word;
- an amount that a register supplied one cycle earlier;
- a doubled rotate for immediate operands;
- a fixed left shift by two for branch offsets;
- a byte-lane rotate derived from the two low address bits;
- a neutral setting that leaves the shifter's carry untouched.

A register-specified shift is a two-step sequence. In the first step, command 111 captures the low byte of the register read bus into an internal 8-bit holding register. In the following cycle, command 000 presents that captured amount together with the shift kind taken from the instruction. An amount of 32 or more cannot be expressed in five bits. In that case the amount output reads zero and a separate over-range flag is raised, so that later logic can apply the large-shift rules.

Shift kinds are encoded as 00 = LSL, 01 = LSR, 10 = ASR, 11 = ROR. Instruction bits 11..5 enter as a 7-bit field: field bit 6 is instruction bit 11 and field bit 0 is instruction bit 5.

Top module: `shsel_top`

## Requirements
- R1: Reset (async, active low, released synchronously) clears the holding register, so a following command 000 yields amount 0, over-range 0.
- R2: Command 111 loads rb_lo into the holding register at the rising clock edge; during that cycle the outputs are amount 0, kind LSL, over-range 0.
- R3: The holding register keeps its value across every command other than 111.
- R4: Command 000 outputs the held amount (when below 32) with kind = field[1:0].
- R5: Command 000 with a held value of 32 or more outputs amount 0 and over-range 1; over-range is 0 in every other case.
- R6: Command 001 outputs amount = field[6:2] and kind = field[1:0].
- R7: Commands 010 and 110 output amount 0, kind LSL, a carry-neutral setting.
- R8: Command 011 outputs amount 2, kind LSL.
- R9: Command 100 outputs amount = 2 × field[6:3]; the kind is ROR when that amount is nonzero and LSL when it is zero.
- R10: Command 101 outputs amount = 8 × addr_lo; the kind is ROR when addr_lo is nonzero and LSL when it is 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd | input | 3 | Shift source command from the sequencer |
| ir_field | input | 7 | Instruction bits 11..5 |
| rb_lo | input | 8 | Low byte of the register read bus |
| addr_lo | input | 2 | Two low address bits |
| amt_o | output | 5 | Shift amount to the barrel shifter |
| kind_o | output | 2 | Shift kind (00 LSL, 01 LSR, 10 ASR, 11 ROR) |
| over_o | output | 1 | Held amount is 32 or more |

## Verification
The held amount can only be observed through a 111-then-000 pair of cycles, and its retention only when other commands come between them. The stimulus loads every one of the 256 bus values and reads each back through command 000. It then inserts a run of non-capturing commands, with a changing bus, and reads the value again to expose any leakage. Values of 32 and above exercise the over-range path. All the other commands are swept over every instruction field and address combination.

// File: rtl/shsel_pkg.sv
package shsel_pkg;
  localparam int unsigned AMT_W = 5;
  localparam int unsigned CMD_W = 3;
  localparam int unsigned SRC_N = 1 << CMD_W;

  typedef enum logic [CMD_W-1:0] {
    C_HELD   = 3'b000,
    C_FIELD  = 3'b001,
    C_NEUTRL = 3'b010,
    C_BRANCH = 3'b011,
    C_IMMROT = 3'b100,
    C_BYTE   = 3'b101,
    C_SPARE  = 3'b110,
    C_LOAD   = 3'b111
  } shcmd_e;

  typedef enum logic [1:0] {
    K_LSL = 2'b00,
    K_LSR = 2'b01,
    K_ASR = 2'b10,
    K_ROR = 2'b11
  } shkind_e;

  typedef struct packed {
    logic [AMT_W-1:0] amt;
    logic [1:0]       kind;
    logic             over;
  } shfld_t;
endpackage

// File: rtl/shsel_rst_sync.sv
module shsel_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/shsel_decode.sv
module shsel_decode #(
  parameter int unsigned CMD_W = 3,
  localparam int unsigned N = 1 << CMD_W
) (
  input  logic [CMD_W-1:0] cmd,
  output logic [N-1:0]     sel
);
  for (genvar i = 0; i < N; i++) begin : g_dec
    assign sel[i] = (cmd == CMD_W'(i));
  end
endmodule

// File: rtl/shsel_hold.sv
module shsel_hold #(
  parameter int unsigned HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [HOLD_W-1:0] d,
  output logic [HOLD_W-1:0] q
);
  logic [HOLD_W-1:0] hold_d;

  always_comb begin
    hold_d = q;
    if (load_en) hold_d = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= hold_d;
  end
endmodule

// File: rtl/shsel_glue.sv
module shsel_glue
  import shsel_pkg::*;
#(
  parameter int unsigned HOLD_W = 8,
  localparam int unsigned FLD_W = AMT_W + 2
) (
  input  logic [FLD_W-1:0]  field,
  input  logic [1:0]        addr_lo,
  input  logic [HOLD_W-1:0] held,
  output shfld_t [SRC_N-1:0] src
);
  localparam int unsigned LIMIT = 1 << AMT_W;

  logic             held_big;
  logic [AMT_W-1:0] imm_amt;
  logic [AMT_W-1:0] byte_amt;

  always_comb begin
    held_big = (int'(held) >= LIMIT);
    imm_amt  = AMT_W'({field[FLD_W-1:FLD_W-4], 1'b0});
    byte_amt = AMT_W'({addr_lo, 3'b000});
  end

  always_comb begin
    src = '0;

    src[C_HELD].amt  = held_big ? '0 : held[AMT_W-1:0];
    src[C_HELD].kind = field[1:0];
    src[C_HELD].over = held_big;

    src[C_FIELD].amt  = field[FLD_W-1:2];
    src[C_FIELD].kind = field[1:0];

    src[C_BRANCH].amt  = AMT_W'(2);
    src[C_BRANCH].kind = K_LSL;

    src[C_IMMROT].amt  = imm_amt;
    src[C_IMMROT].kind = (imm_amt != '0) ? K_ROR : K_LSL;

    src[C_BYTE].amt  = byte_amt;
    src[C_BYTE].kind = (addr_lo != 2'b00) ? K_ROR : K_LSL;
  end
endmodule

// File: rtl/shsel_top.sv
module shsel_top
  import shsel_pkg::*;
#(
  parameter int unsigned HOLD_W = 8,
  localparam int unsigned FLD_W = AMT_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CMD_W-1:0]  cmd,
  input  logic [FLD_W-1:0]  ir_field,
  input  logic [HOLD_W-1:0] rb_lo,
  input  logic [1:0]        addr_lo,
  output logic [AMT_W-1:0]  amt_o,
  output logic [1:0]        kind_o,
  output logic              over_o
);
  logic              rst_n_s;
  logic [SRC_N-1:0]  sel;
  logic [HOLD_W-1:0] held;
  shfld_t [SRC_N-1:0] src;
  shfld_t [SRC_N-1:0] gated;
  shfld_t             res;

  shsel_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  shsel_decode #(.CMD_W(CMD_W)) u_dec (
    .cmd(cmd), .sel(sel)
  );

  shsel_hold #(.HOLD_W(HOLD_W)) u_hold (
    .clk(clk), .rst_n(rst_n_s), .load_en(sel[C_LOAD]),
    .d(rb_lo), .q(held)
  );

  shsel_glue #(.HOLD_W(HOLD_W)) u_glue (
    .field(ir_field), .addr_lo(addr_lo), .held(held), .src(src)
  );

  for (genvar i = 0; i < SRC_N; i++) begin : g_gate
    assign gated[i] = sel[i] ? src[i] : '0;
  end

  always_comb begin
    res = '0;
    for (int i = 0; i < SRC_N; i++) res = res | gated[i];
  end

  assign amt_o  = res.amt;
  assign kind_o = res.kind;
  assign over_o = res.over;
endmodule

// File: rtl/shsel_chk.sv
module shsel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] cmd,
  input logic [7:0] rb_lo,
  input logic [1:0] addr_lo,
  input logic [4:0] amt_o,
  input logic [1:0] kind_o,
  input logic       over_o
);
  p_load_use_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'b111 && rb_lo < 8'd32) |=> (cmd == 3'b000) -> (amt_o == $past(rb_lo[4:0]) && !over_o));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'b000) |=> (cmd == 3'b000) -> (amt_o == $past(amt_o) && over_o == $past(over_o)));

  p_over_r5: assert property (@(posedge clk) disable iff (!rst_n)
    over_o |-> (cmd == 3'b000 && amt_o == 5'd0));

  p_neutral_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'b010 || cmd == 3'b110 || cmd == 3'b111) |-> (amt_o == 5'd0 && kind_o == 2'b00));

  p_branch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'b011) |-> (amt_o == 5'd2 && kind_o == 2'b00));

  p_immrot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'b100) |-> (!amt_o[0] && kind_o == ((amt_o != 5'd0) ? 2'b11 : 2'b00)));

  p_byte_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'b101) |-> (amt_o == {addr_lo, 3'b000}));
endmodule

bind shsel_top shsel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd(cmd), .rb_lo(rb_lo), .addr_lo(addr_lo),
  .amt_o(amt_o), .kind_o(kind_o), .over_o(over_o)
);

// File: tb/shsel_top_test.sv
module shsel_top_test;
  logic       clk;
  logic       rst_n;
  logic [2:0] cmd;
  logic [6:0] ir_field;
  logic [7:0] rb_lo;
  logic [1:0] addr_lo;
  logic [4:0] amt_o;
  logic [1:0] kind_o;
  logic       over_o;

  int unsigned vectors;
  int unsigned errors;

  shsel_top uut (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .ir_field(ir_field),
    .rb_lo(rb_lo), .addr_lo(addr_lo),
    .amt_o(amt_o), .kind_o(kind_o), .over_o(over_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic drive(input logic [2:0] c, input logic [6:0] f,
                       input logic [7:0] r, input logic [1:0] a);
    @(negedge clk);
    cmd = c; ir_field = f; rb_lo = r; addr_lo = a;
    #5;
  endtask

  task automatic check(input string req, input int ea, input int ek, input int eo);
    vectors++;
    if (int'(amt_o) != ea || int'(kind_o) != ek || int'(over_o) != eo) begin
      errors++;
      $display("FAIL %s cmd=%b field=%b rb=%0d addr=%0d: got amt=%0d kind=%0d over=%0d exp amt=%0d kind=%0d over=%0d",
               req, cmd, ir_field, rb_lo, addr_lo, amt_o, kind_o, over_o, ea, ek, eo);
    end
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog: run did not finish, got hang exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    vectors = 0; errors = 0;
    cmd = 3'b000; ir_field = '0; rb_lo = 8'hFF; addr_lo = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: held value cleared by reset
    drive(3'b000, 7'b0000011, 8'hAB, 2'd0);
    check("R1", 0, 3, 0);

    // R6, R7, R8, R9, R10: full sweep of field and address
    for (int f = 0; f < 128; f++) begin
      for (int a = 0; a < 4; a++) begin
        drive(3'b001, 7'(f), 8'(f * 3), 2'(a));
        check("R6", f / 4, f % 4, 0);
        drive(3'b010, 7'(f), 8'(f), 2'(a));
        check("R7", 0, 0, 0);
        drive(3'b110, 7'(f), 8'(f), 2'(a));
        check("R7", 0, 0, 0);
        drive(3'b011, 7'(f), 8'(f), 2'(a));
        check("R8", 2, 0, 0);
        drive(3'b100, 7'(f), 8'(f), 2'(a));
        check("R9", 2 * (f / 8), ((f / 8) != 0) ? 3 : 0, 0);
        drive(3'b101, 7'(f), 8'(f), 2'(a));
        check("R10", 8 * a, (a != 0) ? 3 : 0, 0);
      end
    end

    // R1 again: the sweep never used command 111, so held stays zero (R3)
    drive(3'b000, 7'b0000001, 8'h55, 2'd2);
    check("R3", 0, 1, 0);

    // R2, R4, R5, R3: load each bus value, use it, disturb, use again
    for (int v = 0; v < 256; v++) begin
      int ea;
      int eo;
      eo = (v >= 32) ? 1 : 0;
      ea = (v >= 32) ? 0 : v;
      drive(3'b111, 7'(v), 8'(v), 2'(v));
      check("R2", 0, 0, 0);
      drive(3'b000, 7'(v % 4), 8'(255 - v), 2'd1);
      check((v >= 32) ? "R5" : "R4", ea, v % 4, eo);
      drive(3'b101, 7'd9, 8'(v + 17), 2'd3);
      check("R10", 24, 3, 0);
      drive(3'b010, 7'd0, 8'(v ^ 8'hA5), 2'd0);
      check("R7", 0, 0, 0);
      drive(3'b000, 7'((v + 1) % 4), 8'(v + 99), 2'd0);
      check("R3", ea, (v + 1) % 4, eo);
    end

    // R1: reset mid-run clears a nonzero held amount
    drive(3'b111, 7'd0, 8'd13, 2'd0);
    @(negedge clk);
    cmd = 3'b000;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    drive(3'b000, 7'd2, 8'd7, 2'd0);
    check("R1", 0, 2, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule